// File: doc/BRIEF.md
# Asynchronous Memory Interface Sequencer

This block runs single accesses from an internal requester to asynchronous memories or peripherals that sit on up to four chip-select lines. Each access goes through up to four phases in a fixed order: an optional bus turnaround gap, address setup, the strobe (output enable for reads, write enable for writes), and a hold tail. Each chip select has its own cycle counts. Setup, strobe and hold are held separately for reads and for writes. A single turnaround count applies to both directions.

The turnaround gap comes before the access. It is inserted only when the pending access goes to a different chip select than the last completed access, or reverses the read/write direction on the same chip select. Its length is taken from the pending chip select's configuration. The requester keeps its valid flag high for the whole access. If the flag has dropped when the turnaround gap ends, the access is dropped without touching the strobe lines. Request fields are latched when the access is accepted.

Top module: `async_mem_seq`

## Requirements
- R1: The phases run as turnaround, setup, strobe, hold. Only the selected chip-select line (active low, bit index = chip-select number) is low, from the first setup cycle to the last hold cycle. `oe_n_o` (reads) or `we_n_o` (writes) is low only during strobe. All lines are high in turnaround and idle.
- R2: A programmed setup, strobe or hold value N gives N+1 cycles. The value is taken from the selected chip select's field for the access direction. Fields are packed with chip select k at bits [k*W +: W].
- R3: When the chip select differs from the last completed access, or the direction differs, exactly T turnaround cycles (T = the pending chip select's 2-bit count, 0 allowed) separate acceptance from the first setup cycle.
- R4: A read after a read, or a write after a write, to the same chip select gets no turnaround cycles.
- R5: Hold cycles are applied on every access, including back-to-back same-direction accesses to one chip select.
- R6: If `req_valid_i` is low when turnaround ends, the access is dropped. No chip select, strobe or done is raised, and the sequencer returns to idle.
- R7: After reset, the last access counts as a read to chip select 0. Only a completed access updates the last chip select and direction; a dropped one leaves them unchanged.
- R8: On writes, `dq_oe_o` is high and `dq_o` carries the write data from setup through hold. On reads and in idle and turnaround, `dq_oe_o` is low. `addr_o` holds the request address while a chip select is low.
- R9: Read data is the value on `dq_i` in the last strobe cycle. It is presented on `rdata_o` from the done cycle onward.
- R10: `done_o` is high for exactly one cycle, the last hold cycle. A request present in the following cycle is accepted in that cycle.
- R11: During and after reset with no request, all strobe and chip-select lines are high, and `dq_oe_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_turn_i | input | NUM_CS*TA_W | Turnaround count per chip select |
| cfg_rd_setup_i | input | NUM_CS*SU_W | Read setup count per chip select |
| cfg_rd_strobe_i | input | NUM_CS*ST_W | Read strobe count per chip select |
| cfg_rd_hold_i | input | NUM_CS*HD_W | Read hold count per chip select |
| cfg_wr_setup_i | input | NUM_CS*SU_W | Write setup count per chip select |
| cfg_wr_strobe_i | input | NUM_CS*ST_W | Write strobe count per chip select |
| cfg_wr_hold_i | input | NUM_CS*HD_W | Write hold count per chip select |
| req_valid_i | input | 1 | Request present; must stay high until done |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | CS_W | Target chip select |
| req_addr_i | input | ADDR_W | Address |
| req_wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-cycle completion pulse |
| cs_n_o | output | NUM_CS | Chip-select lines, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | External address |
| dq_o | output | DATA_W | Data bus output value |
| dq_oe_o | output | 1 | Data bus drive enable |
| dq_i | input | DATA_W | Data bus input value |

## Verification
The turnaround gap is measured across a sequence built to tell the cases apart: same select and same direction, a direction flip, a change of select, and a select whose count is zero. Each select has its own turnaround count, so reading the count from the wrong select shows up as a wrong gap. A dropped request is followed by an access whose gap reveals whether the last-access record was disturbed. The external read model changes its data on every strobe cycle, so capturing the wrong cycle gives a different value. Setup, strobe and hold use different counts per select and direction, so a mixed-up field lengthens or shortens a phase.

// File: rtl/async_seq_pkg.sv
// Shared types for the asynchronous memory sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package async_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_TURN   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4
    } seq_phase_t;
endpackage

// File: rtl/async_seq_count.sv
// Phase down-counter: loads a cycle count and steps to zero.
// Assumes load_i and the decrement never coincide with a wrap past zero.
module async_seq_count #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Load a new phase length or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= val_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
endmodule

// File: rtl/async_seq_cfg_sel.sv
// Picks the timing fields of one chip select and direction from the packed
// per-select configuration vectors. Assumes sel_cs_i < NUM_CS.
module async_seq_cfg_sel #(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2,
    parameter int TA_W   = 2,
    parameter int SU_W   = 4,
    parameter int ST_W   = 6,
    parameter int HD_W   = 3
) (
    input  logic [NUM_CS*TA_W-1:0] turn_i,
    input  logic [NUM_CS*SU_W-1:0] rd_su_i,
    input  logic [NUM_CS*ST_W-1:0] rd_st_i,
    input  logic [NUM_CS*HD_W-1:0] rd_hd_i,
    input  logic [NUM_CS*SU_W-1:0] wr_su_i,
    input  logic [NUM_CS*ST_W-1:0] wr_st_i,
    input  logic [NUM_CS*HD_W-1:0] wr_hd_i,
    input  logic [CS_W-1:0]        sel_cs_i,
    input  logic                   sel_wr_i,
    output logic [TA_W-1:0]        ta_o,
    output logic [SU_W-1:0]        su_o,
    output logic [ST_W-1:0]        st_o,
    output logic [HD_W-1:0]        hd_o
);
    // Index the packed fields for the chosen select and direction.
    always_comb begin
        ta_o = turn_i[sel_cs_i*TA_W +: TA_W];
        su_o = sel_wr_i ? wr_su_i[sel_cs_i*SU_W +: SU_W] : rd_su_i[sel_cs_i*SU_W +: SU_W];
        st_o = sel_wr_i ? wr_st_i[sel_cs_i*ST_W +: ST_W] : rd_st_i[sel_cs_i*ST_W +: ST_W];
        hd_o = sel_wr_i ? wr_hd_i[sel_cs_i*HD_W +: HD_W] : rd_hd_i[sel_cs_i*HD_W +: HD_W];
    end
endmodule

// File: rtl/async_seq_ta_track.sv
// Remembers the chip select and direction of the last completed access and
// flags when a candidate access needs a turnaround gap. Reset state is a
// read to chip select 0. Assumes upd_i pulses once per completed access.
module async_seq_ta_track #(
    parameter int CS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CS_W-1:0] cand_cs_i,
    input  logic            cand_wr_i,
    input  logic            upd_i,
    input  logic [CS_W-1:0] upd_cs_i,
    input  logic            upd_wr_i,
    output logic            need_ta_o
);
    logic [CS_W-1:0] prev_cs_q;
    logic            prev_wr_q;

    // Record the last access only when one completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cs_q <= '0;
            prev_wr_q <= 1'b0;
        end else if (upd_i) begin
            prev_cs_q <= upd_cs_i;
            prev_wr_q <= upd_wr_i;
        end
    end

    assign need_ta_o = (cand_cs_i != prev_cs_q) || (cand_wr_i != prev_wr_q);

    AST_PREV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> ($stable(prev_cs_q) && $stable(prev_wr_q))); // R7
endmodule

// File: rtl/async_mem_seq.sv
// Asynchronous memory interface sequencer. Runs one access at a time through
// turnaround, setup, strobe and hold, with per-select cycle counts.
// Assumes the requester holds req_valid_i high until done_o; request fields
// are latched on acceptance.
module async_mem_seq
    import async_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int TA_W   = 2,
    parameter int SU_W   = 4,
    parameter int ST_W   = 6,
    parameter int HD_W   = 3,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CS*TA_W-1:0] cfg_turn_i,
    input  logic [NUM_CS*SU_W-1:0] cfg_rd_setup_i,
    input  logic [NUM_CS*ST_W-1:0] cfg_rd_strobe_i,
    input  logic [NUM_CS*HD_W-1:0] cfg_rd_hold_i,
    input  logic [NUM_CS*SU_W-1:0] cfg_wr_setup_i,
    input  logic [NUM_CS*ST_W-1:0] cfg_wr_strobe_i,
    input  logic [NUM_CS*HD_W-1:0] cfg_wr_hold_i,
    input  logic                   req_valid_i,
    input  logic                   req_write_i,
    input  logic [CS_W-1:0]        req_cs_i,
    input  logic [ADDR_W-1:0]      req_addr_i,
    input  logic [DATA_W-1:0]      req_wdata_i,
    output logic [DATA_W-1:0]      rdata_o,
    output logic                   done_o,
    output logic [NUM_CS-1:0]      cs_n_o,
    output logic                   oe_n_o,
    output logic                   we_n_o,
    output logic [ADDR_W-1:0]      addr_o,
    output logic [DATA_W-1:0]      dq_o,
    output logic                   dq_oe_o,
    input  logic [DATA_W-1:0]      dq_i
);
    localparam int W_A   = (TA_W > SU_W) ? TA_W : SU_W;
    localparam int W_B   = (ST_W > HD_W) ? ST_W : HD_W;
    localparam int CNT_W = (W_A > W_B) ? W_A : W_B;

    seq_phase_t        ph_q, ph_d;
    logic [CS_W-1:0]   cur_cs_q;
    logic              cur_wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [CS_W-1:0]   sel_cs;
    logic              sel_wr, need_ta, cnt_zero, cnt_load, on_bus;
    logic [CNT_W-1:0]  cnt_val;
    logic [TA_W-1:0]   ta_sel;
    logic [SU_W-1:0]   su_sel;
    logic [ST_W-1:0]   st_sel;
    logic [HD_W-1:0]   hd_sel;

    // While idle the incoming request picks the config; afterwards the latched one.
    assign sel_cs = (ph_q == PH_IDLE) ? req_cs_i    : cur_cs_q;
    assign sel_wr = (ph_q == PH_IDLE) ? req_write_i : cur_wr_q;

    async_seq_cfg_sel #(
        .NUM_CS(NUM_CS), .CS_W(CS_W), .TA_W(TA_W),
        .SU_W(SU_W), .ST_W(ST_W), .HD_W(HD_W)
    ) u_cfg (
        .turn_i(cfg_turn_i), .rd_su_i(cfg_rd_setup_i), .rd_st_i(cfg_rd_strobe_i),
        .rd_hd_i(cfg_rd_hold_i), .wr_su_i(cfg_wr_setup_i), .wr_st_i(cfg_wr_strobe_i),
        .wr_hd_i(cfg_wr_hold_i), .sel_cs_i(sel_cs), .sel_wr_i(sel_wr),
        .ta_o(ta_sel), .su_o(su_sel), .st_o(st_sel), .hd_o(hd_sel)
    );

    async_seq_ta_track #(.CS_W(CS_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .cand_cs_i(sel_cs), .cand_wr_i(sel_wr),
        .upd_i(done_o), .upd_cs_i(cur_cs_q), .upd_wr_i(cur_wr_q),
        .need_ta_o(need_ta)
    );

    async_seq_count #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(cnt_load), .val_i(cnt_val), .zero_o(cnt_zero)
    );

    // Choose the next phase and the count to load on each phase entry.
    always_comb begin
        ph_d     = ph_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (ph_q)
            PH_IDLE: if (req_valid_i) begin
                cnt_load = 1'b1;
                if (need_ta && ta_sel != '0) begin
                    ph_d    = PH_TURN;
                    cnt_val = CNT_W'(ta_sel) - CNT_W'(1);
                end else begin
                    ph_d    = PH_SETUP;
                    cnt_val = CNT_W'(su_sel);
                end
            end
            PH_TURN: if (cnt_zero) begin
                if (req_valid_i) begin
                    ph_d     = PH_SETUP;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(su_sel);
                end else begin
                    ph_d = PH_IDLE;
                end
            end
            PH_SETUP: if (cnt_zero) begin
                ph_d     = PH_STROBE;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(st_sel);
            end
            PH_STROBE: if (cnt_zero) begin
                ph_d     = PH_HOLD;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(hd_sel);
            end
            PH_HOLD: if (cnt_zero) ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Latch the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cs_q <= '0;
            cur_wr_q <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else if (ph_q == PH_IDLE && req_valid_i) begin
            cur_cs_q <= req_cs_i;
            cur_wr_q <= req_write_i;
            addr_q   <= req_addr_i;
            wdata_q  <= req_wdata_i;
        end
    end

    // Capture read data in the final strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (ph_q == PH_STROBE && cnt_zero && !cur_wr_q) rdata_q <= dq_i;
    end

    assign on_bus  = (ph_q == PH_SETUP) || (ph_q == PH_STROBE) || (ph_q == PH_HOLD);
    assign done_o  = (ph_q == PH_HOLD) && cnt_zero;
    assign oe_n_o  = !((ph_q == PH_STROBE) && !cur_wr_q);
    assign we_n_o  = !((ph_q == PH_STROBE) && cur_wr_q);
    assign dq_oe_o = on_bus && cur_wr_q;
    assign dq_o    = wdata_q;
    assign addr_o  = addr_q;
    assign rdata_o = rdata_q;

    // One chip-select line per select, low only while on the bus.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n_o[g] = !(on_bus && cur_cs_q == CS_W'(g));
    end

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n_o) <= 1); // R1
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n_o || !we_n_o) |-> (cs_n_o != '1)); // R1
    AST_NO_OE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n_o && !we_n_o)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_TURN && cnt_zero && !req_valid_i) |=> (ph_q == PH_IDLE && cs_n_o == '1)); // R6
    AST_WR_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> dq_oe_o); // R8
endmodule

// File: tb/async_mem_seq_test.sv
`timescale 1ns/1ps
module async_mem_seq_test;
    localparam int NCS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NCS*2-1:0] cfg_turn;
    logic [NCS*4-1:0] cfg_rsu, cfg_wsu;
    logic [NCS*6-1:0] cfg_rst, cfg_wst;
    logic [NCS*3-1:0] cfg_rhd, cfg_whd;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [15:0] rdata, addr_o, dq_o, dq_i;
    logic        done, oe_n, we_n, dq_oe;
    logic [3:0]  cs_n;
    logic [5:0]  stb_ctr;

    int ta_t[NCS]  = '{2, 1, 3, 0};
    int rsu_t[NCS] = '{1, 0, 2, 3};
    int rst_t[NCS] = '{2, 1, 4, 0};
    int rhd_t[NCS] = '{0, 1, 2, 3};
    int wsu_t[NCS] = '{2, 3, 0, 1};
    int wst_t[NCS] = '{3, 0, 1, 2};
    int whd_t[NCS] = '{1, 2, 0, 3};

    int checks = 0, fails = 0;
    int prev_cs = 0;
    logic prev_wr = 1'b0;

    async_mem_seq uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_turn_i(cfg_turn), .cfg_rd_setup_i(cfg_rsu), .cfg_rd_strobe_i(cfg_rst),
        .cfg_rd_hold_i(cfg_rhd), .cfg_wr_setup_i(cfg_wsu), .cfg_wr_strobe_i(cfg_wst),
        .cfg_wr_hold_i(cfg_whd),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_cs_i(req_cs),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rdata_o(rdata), .done_o(done), .cs_n_o(cs_n), .oe_n_o(oe_n), .we_n_o(we_n),
        .addr_o(addr_o), .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_i)
    );

    // External read model: data changes on every strobe cycle.
    always @(posedge clk) stb_ctr <= oe_n ? 6'd0 : stb_ctr + 6'd1;
    assign dq_i = oe_n ? 16'h0000 : ((addr_o ^ 16'hA5C3) ^ {10'b0, stb_ctr});

    initial begin
        for (int k = 0; k < NCS; k++) begin
            cfg_turn[k*2 +: 2] = 2'(ta_t[k]);
            cfg_rsu[k*4 +: 4]  = 4'(rsu_t[k]);
            cfg_rst[k*6 +: 6]  = 6'(rst_t[k]);
            cfg_rhd[k*3 +: 3]  = 3'(rhd_t[k]);
            cfg_wsu[k*4 +: 4]  = 4'(wsu_t[k]);
            cfg_wst[k*6 +: 6]  = 6'(wst_t[k]);
            cfg_whd[k*3 +: 3]  = 3'(whd_t[k]);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One full access with phase measurement; called and returns at a negedge.
    task automatic do_access(input logic wr, input int cs, input logic [15:0] a,
                             input logic [15:0] wd, input string ta_req);
        int n_ta = 0, n_su = 0, n_st = 0, n_hd = 0, n_done = 0, bad_ln = 0, bad_bus = 0;
        bit seen_cs = 0, seen_stb = 0, fin = 0;
        bit need = (cs != prev_cs) || (wr != prev_wr);
        int exp_ta = need ? ta_t[cs] : 0;
        int exp_su = (wr ? wsu_t[cs] : rsu_t[cs]) + 1;
        int exp_st = (wr ? wst_t[cs] : rst_t[cs]) + 1;
        int exp_hd = (wr ? whd_t[cs] : rhd_t[cs]) + 1;
        logic [15:0] exp_rd = (a ^ 16'hA5C3) ^ 16'(exp_st - 1);
        req_write = wr; req_cs = 2'(cs); req_addr = a; req_wdata = wd; req_valid = 1'b1;
        for (int k = 0; k < 200 && !fin; k++) begin
            @(negedge clk);
            if (cs_n == 4'hF) begin
                if (seen_cs || !oe_n || !we_n) bad_ln++;
                else n_ta++;
                if (dq_oe) bad_bus++;
            end else begin
                seen_cs = 1;
                if (cs_n != ~(4'b1 << cs)) bad_ln++;
                if (!oe_n || !we_n) begin
                    seen_stb = 1; n_st++;
                    if (wr ? (we_n || !oe_n) : (oe_n || !we_n)) bad_ln++;
                end else if (!seen_stb) n_su++;
                else n_hd++;
                if (wr ? (!dq_oe || dq_o != wd) : dq_oe) bad_bus++;
                if (addr_o != a) bad_bus++;
            end
            if (done) begin n_done++; fin = 1; end
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(n_ta == exp_ta, ta_req, n_ta, exp_ta);
        chk(n_su == exp_su, "R2 setup", n_su, exp_su);
        chk(n_st == exp_st, "R2 strobe", n_st, exp_st);
        chk(n_hd == exp_hd, "R5 hold", n_hd, exp_hd);
        chk(bad_ln == 0, "R1 lines", bad_ln, 0);
        chk(bad_bus == 0, "R8 bus", bad_bus, 0);
        chk(n_done == 1 && !done && cs_n == 4'hF, "R10 done", n_done, 1);
        if (!wr) chk(rdata == exp_rd, "R9 rdata", rdata, exp_rd);
        prev_cs = cs; prev_wr = wr;
    endtask

    // Request withdrawn during turnaround: nothing reaches the bus.
    task automatic do_abort(input logic wr, input int cs);
        int bad = 0;
        req_write = wr; req_cs = 2'(cs); req_addr = 16'h0BAD; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (cs_n != 4'hF || !oe_n || !we_n || done || dq_oe) bad++;
        end
        chk(bad == 0, "R6 abort", bad, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(cs_n == 4'hF && oe_n && we_n && !dq_oe && !done, "R11 reset", {cs_n, oe_n, we_n}, 6'h3F);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n == 4'hF && !done, "R11 idle", cs_n, 4'hF);
    endtask

    initial begin
        t_reset();
        do_access(1'b0, 0, 16'h1200, 16'h0, "R7 reset prev cs0 read");
        do_access(1'b0, 0, 16'h1234, 16'h0, "R4 rd-rd same cs");
        do_access(1'b1, 0, 16'h2000, 16'hBEEF, "R3 dir flip");
        do_access(1'b1, 0, 16'h2002, 16'h1357, "R4 wr-wr same cs");
        do_access(1'b0, 1, 16'h3000, 16'h0, "R3 cs change uses pending cs");
        do_access(1'b0, 3, 16'h4000, 16'h0, "R3 zero count");
        do_access(1'b0, 2, 16'h5000, 16'h0, "R3 cs change long");
        do_abort(1'b1, 1);
        do_access(1'b0, 2, 16'h5004, 16'h0, "R7 abort keeps prev");
        do_access(1'b1, 3, 16'h6000, 16'hCAFE, "R3 cs and dir change");
        do_access(1'b1, 3, 16'h6002, 16'h0F0F, "R5 back-to-back");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule